// File: doc/BRIEF.md
# Legacy Switch Command Serializer

This block sends a seven-bit command word for an older satellite-dish switch over one output wire. A start strobe in the idle state captures the word. The block then drives a long high start pulse and a short low lead gap. After that it sends the data bits, least significant first. Each data bit holds its level for a fixed bit period and is followed by a fixed low gap. The wire idles low. A busy flag covers the whole frame. Strobes that arrive while the flag is high are discarded.

All durations are counted in time units. One time unit is `PRESCALE` clock cycles. The start pulse lasts `START_UNITS` units (32 by default). The lead gap and every inter-bit gap last `GAP_UNITS` units (8 by default). Each data bit lasts `BIT_UNITS` units (8 by default). With the defaults and `PRESCALE` = 4, a frame is 128 + 32 + 7 × 64 = 608 cycles long. The command input is eight bits wide so that a full switch byte can be connected directly. Its top bit carries a separate setting that another block handles, and this block does not use it.

Top module: `switch_word_tx`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `line_o` is low and `busy_o` is low.
- R2: When `start_i` is high at a rising edge while idle, the frame is accepted. `busy_o` and `line_o` are both high in the next cycle.
- R3: The first START_UNITS×PRESCALE cycles of a frame drive `line_o` high.
- R4: The start pulse is followed by GAP_UNITS×PRESCALE cycles with `line_o` low.
- R5: Data bit j (j = 0..6, bit 0 first) of `cmd_i` drives `line_o` for BIT_UNITS×PRESCALE cycles, starting at cycle offset START+GAP+j×(BIT+GAP), where every length is in cycles.
- R6: Each data bit is followed by GAP_UNITS×PRESCALE low cycles, including the bit that is sent last.
- R7: `cmd_i[7]` has no effect on the waveform.
- R8: `busy_o` stays high for exactly START+GAP+7×(BIT+GAP) cycles and then falls.
- R9: A strobe that arrives while `busy_o` is high is ignored. The running frame neither restarts nor extends.
- R10: The word is captured at acceptance. Changes on `cmd_i` during a frame have no effect.
- R11: A synchronous reset during a frame forces `line_o` and `busy_o` low at the next edge.
- R12: When `start_i` is held high across the end of a frame, `busy_o` is low for one cycle and a new frame then starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled at each rising edge |
| cmd_i | input | 8 | Command byte; bits 6..0 are sent, bit 7 is unused |
| line_o | output | 1 | Serial switch line, idles low |
| busy_o | output | 1 | High for the whole frame |

## Verification
The hardest case to reach is a strobe that lands exactly on the final edge of a frame. At that edge the sequencer leaves its last gap. A strobe there must be dropped, and the same strobe must be taken one cycle later. The bench holds `start_i` high continuously through the end of a frame. It then checks for exactly one low cycle of `busy_o`, followed by a fresh start pulse. Other frames toggle the strobe or invert `cmd_i` on every cycle of the frame. Each of these frames is compared, cycle by cycle, against a waveform that the bench computes itself.

// File: rtl/sws_pkg.sv
package sws_pkg;

    localparam int unsigned WORD_W = 7;
    localparam int unsigned CMD_W  = WORD_W + 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_LEAD,
        PH_DATA,
        PH_SPACE
    } phase_e;

    typedef struct packed {
        logic load;
        logic advance;
    } shift_ctl_t;

    function automatic int unsigned phase_units(
        input phase_e      ph,
        input int unsigned start_u,
        input int unsigned gap_u,
        input int unsigned bit_u
    );
        case (ph)
            PH_START: return start_u;
            PH_LEAD:  return gap_u;
            PH_DATA:  return bit_u;
            PH_SPACE: return gap_u;
            default:  return 1;
        endcase
    endfunction

    function automatic int unsigned max3(
        input int unsigned a,
        input int unsigned b,
        input int unsigned c
    );
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sws_unit_timer.sv
module sws_unit_timer #(
    parameter int unsigned PRESCALE = 4,
    parameter int unsigned UW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [UW-1:0] len_units,
    output logic          phase_end
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PW-1:0] pre_q;
    logic [UW-1:0] unit_q;
    logic          tick;

    assign tick      = run && (pre_q == PW'(PRESCALE - 1));
    assign phase_end = tick && (unit_q == len_units - UW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else begin
            if (tick) begin
                pre_q <= '0;
                if (phase_end) begin
                    unit_q <= '0;
                end else begin
                    unit_q <= unit_q + UW'(1);
                end
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

endmodule

// File: rtl/sws_shifter.sv
module sws_shifter
    import sws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl,
    input  logic [WORD_W-1:0] word,
    output logic              cur_bit,
    output logic              last_bit
);
    localparam int unsigned IW = $clog2(WORD_W);

    logic [WORD_W-1:0] data_q;
    logic [IW-1:0]     idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            idx_q  <= '0;
        end else if (ctl.load) begin
            data_q <= word;
            idx_q  <= '0;
        end else if (ctl.advance) begin
            data_q <= {1'b0, data_q[WORD_W-1:1]};
            idx_q  <= idx_q + IW'(1);
        end
    end

    assign cur_bit  = data_q[0];
    assign last_bit = (idx_q == IW'(WORD_W - 1));

endmodule

// File: rtl/sws_sequencer.sv
module sws_sequencer
    import sws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       phase_end,
    input  logic       last_bit,
    output phase_e     phase,
    output shift_ctl_t ctl
);
    phase_e ph_q, ph_d;

    always_comb begin
        ph_d        = ph_q;
        ctl.load    = 1'b0;
        ctl.advance = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    ph_d     = PH_START;
                    ctl.load = 1'b1;
                end
            end
            PH_START: if (phase_end) ph_d = PH_LEAD;
            PH_LEAD:  if (phase_end) ph_d = PH_DATA;
            PH_DATA:  if (phase_end) ph_d = PH_SPACE;
            PH_SPACE: begin
                if (phase_end) begin
                    if (last_bit) begin
                        ph_d = PH_IDLE;
                    end else begin
                        ph_d        = PH_DATA;
                        ctl.advance = 1'b1;
                    end
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign phase = ph_q;

endmodule

// File: rtl/switch_word_tx.sv
module switch_word_tx
    import sws_pkg::*;
#(
    parameter int unsigned PRESCALE    = 4,
    parameter int unsigned START_UNITS = 32,
    parameter int unsigned GAP_UNITS   = 8,
    parameter int unsigned BIT_UNITS   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic             line_o,
    output logic             busy_o
);
    localparam int unsigned MAX_U = max3(START_UNITS, GAP_UNITS, BIT_UNITS);
    localparam int unsigned UW    = $clog2(MAX_U + 1);

    phase_e        phase;
    shift_ctl_t    ctl;
    logic          phase_end;
    logic          cur_bit;
    logic          last_bit;
    logic [UW-1:0] len_units;
    logic          unused_hi;

    // The top command bit belongs to another block.
    assign unused_hi = cmd_i[CMD_W-1];

    assign len_units = UW'(phase_units(phase, START_UNITS, GAP_UNITS, BIT_UNITS));

    sws_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .phase_end (phase_end),
        .last_bit  (last_bit),
        .phase     (phase),
        .ctl       (ctl)
    );

    sws_unit_timer #(
        .PRESCALE (PRESCALE),
        .UW       (UW)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (phase != PH_IDLE),
        .len_units (len_units),
        .phase_end (phase_end)
    );

    sws_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .word     (cmd_i[WORD_W-1:0]),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    assign line_o = (phase == PH_START) || ((phase == PH_DATA) && cur_bit);
    assign busy_o = (phase != PH_IDLE);

endmodule

// File: rtl/switch_word_tx_chk.sv
module switch_word_tx_chk #(
    parameter int unsigned PRESCALE    = 4,
    parameter int unsigned START_UNITS = 32,
    parameter int unsigned GAP_UNITS   = 8,
    parameter int unsigned BIT_UNITS   = 8
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic line_o,
    input logic busy_o
);
    localparam logic [31:0] S_C = 32'(START_UNITS * PRESCALE);
    localparam logic [31:0] G_C = 32'(GAP_UNITS * PRESCALE);
    localparam logic [31:0] B_C = 32'(BIT_UNITS * PRESCALE);
    localparam logic [31:0] N_C = S_C + G_C + 32'd7 * (B_C + G_C);

    logic [31:0] cnt_q;
    logic [31:0] dpos;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) cnt_q <= '0;
        else                cnt_q <= cnt_q + 32'd1;
    end

    assign dpos = cnt_q - S_C - G_C;

    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !line_o);

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    p_start_high_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q < S_C) |-> line_o);

    p_lead_low_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q >= S_C && cnt_q < S_C + G_C) |-> !line_o);

    p_gap_low_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q >= S_C + G_C && (dpos % (B_C + G_C)) >= B_C) |-> !line_o);

    p_frame_end_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q == N_C - 32'd1) |=> !busy_o);

    p_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (cnt_q < N_C));

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q < N_C - 32'd1) |=> busy_o);

endmodule

bind switch_word_tx switch_word_tx_chk #(
    .PRESCALE    (PRESCALE),
    .START_UNITS (START_UNITS),
    .GAP_UNITS   (GAP_UNITS),
    .BIT_UNITS   (BIT_UNITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .line_o  (line_o),
    .busy_o  (busy_o)
);

// File: tb/switch_word_tx_bench.sv
`timescale 1ns/1ps
module switch_word_tx_bench;

    localparam int PRESCALE = 4;
    localparam int S_C = 32 * PRESCALE;
    localparam int G_C = 8 * PRESCALE;
    localparam int B_C = 8 * PRESCALE;
    localparam int N_C = S_C + G_C + 7 * (B_C + G_C);

    // mode: 0 plain, 1 strobe toggling during frame, 2 cmd_i inverted during frame
    typedef struct packed {
        logic [7:0] word;
        logic [6:0] exp;
        logic [1:0] mode;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 7'h01, 2'd0},
        '{8'h40, 7'h40, 2'd0},
        '{8'h55, 7'h55, 2'd0},
        '{8'h2A, 7'h2A, 2'd0},
        '{8'hFF, 7'h7F, 2'd0},   // R7: top bit must not show
        '{8'h80, 7'h00, 2'd0},   // R7
        '{8'h33, 7'h33, 2'd1},   // R9
        '{8'h4C, 7'h4C, 2'd2}    // R10
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] cmd_i = 8'h00;
    logic       line_o;
    logic       busy_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    switch_word_tx u_switch_word_tx (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cmd_i   (cmd_i),
        .line_o  (line_o),
        .busy_o  (busy_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_line(input int k, input logic [6:0] w);
        int r;
        if (k < S_C) return 1;
        r = k - S_C;
        if (r < G_C) return 0;
        r = r - G_C;
        if ((r % (B_C + G_C)) < B_C) return int'(w[r / (B_C + G_C)]);
        return 0;
    endfunction

    function automatic int region(input int k);
        int r;
        if (k < S_C) return 0;
        if (k < S_C + G_C) return 1;
        r = k - S_C - G_C;
        if ((r % (B_C + G_C)) < B_C) return 2;
        return 3;
    endfunction

    // Runs one frame, comparing every cycle against the computed waveform.
    task automatic run_frame(input logic [7:0] word, input logic [6:0] expw,
                             input int mode, input string dtag);
        int bad [5];
        int fa  [5];
        int fe  [5];
        for (int i = 0; i < 5; i++) begin
            bad[i] = 0; fa[i] = 0; fe[i] = 0;
        end
        @(negedge clk);
        start_i = 1'b1;
        cmd_i   = word;
        @(negedge clk);
        check(busy_o === 1'b1, "R2 busy after strobe", int'(busy_o), 1);
        for (int k = 0; k < N_C; k++) begin
            int e;
            int rg;
            e  = exp_line(k, expw);
            rg = region(k);
            if (int'(line_o) != e) begin
                if (bad[rg] == 0) begin fa[rg] = int'(line_o); fe[rg] = e; end
                bad[rg]++;
            end
            if (busy_o !== 1'b1) begin
                if (bad[4] == 0) begin fa[4] = int'(busy_o); fe[4] = 1; end
                bad[4]++;
            end
            case (mode)
                1: start_i = k[0];
                2: begin start_i = 1'b0; cmd_i = ~word; end
                3: start_i = 1'b1;
                default: start_i = 1'b0;
            endcase
            if (k == N_C - 1 && mode != 3) start_i = 1'b0;
            @(negedge clk);
        end
        check(bad[0] == 0, "R3 start pulse high", fa[0], fe[0]);
        check(bad[1] == 0, "R4 lead gap low", fa[1], fe[1]);
        check(bad[2] == 0, dtag, fa[2], fe[2]);
        check(bad[3] == 0, "R6 inter-bit gaps low", fa[3], fe[3]);
        check(bad[4] == 0, "R8 busy held through frame", fa[4], fe[4]);
        check(busy_o === 1'b0 && line_o === 1'b0, "R8 busy falls after final gap",
              int'({busy_o, line_o}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(line_o === 1'b0 && busy_o === 1'b0, "R1 reset state", int'({busy_o, line_o}), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(line_o === 1'b0 && busy_o === 1'b0, "R1 idle after reset", int'({busy_o, line_o}), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            string t;
            case (VECS[v].mode)
                2'd1: t = "R9 data under strobes";
                2'd2: t = "R10 data under cmd change";
                default: t = VECS[v].word[7] ? "R7 data bits" : "R5 data bits";
            endcase
            run_frame(VECS[v].word, VECS[v].exp, int'(VECS[v].mode), t);
            repeat (3) @(negedge clk);
        end

        // R12: strobe held across end of frame
        run_frame(8'h12, 7'h12, 3, "R5 data before back-to-back");
        @(negedge clk);
        check(busy_o === 1'b1 && line_o === 1'b1, "R12 restart after one idle cycle",
              int'({busy_o, line_o}), 3);
        start_i = 1'b0;
        repeat (N_C + 4) @(negedge clk);
        check(busy_o === 1'b0, "R12 second frame ends", int'(busy_o), 0);

        // R11: reset in the middle of a frame (during start pulse, then data)
        start_i = 1'b1; cmd_i = 8'h7F;
        @(negedge clk);
        start_i = 1'b0;
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(line_o === 1'b0 && busy_o === 1'b0, "R11 reset during start pulse",
              int'({busy_o, line_o}), 0);
        rst = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (S_C + G_C + 5) @(negedge clk);
        check(line_o === 1'b1, "R5 first bit of 7F high", int'(line_o), 1);
        rst = 1'b1;
        @(negedge clk);
        check(line_o === 1'b0 && busy_o === 1'b0, "R11 reset during data bit",
              int'({busy_o, line_o}), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(line_o === 1'b0 && busy_o === 1'b0, "R1 idle stays low after reset",
              int'({busy_o, line_o}), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule